// File: doc/BRIEF.md
# Frame Alignment Loss Event Counter

This block counts alignment trouble seen by a T1/J1 framer receiver and gives a host a safe way to read the total. One 8-bit word holds two saturating fields. The upper six bits count multiframe periods spent out of alignment. The lower two bits count alignment changes. The framer's alignment logic and the one-second timer sit outside the block. They arrive here as strobes and levels.

A readable snapshot register sits between the live counter and the host. There are two readout modes. In snapshot mode the snapshot follows the live count on every clock. The host sets a freeze request to hold the snapshot and zero the live count in the same edge. A read of the high-byte address then ends the freeze. In periodic mode each one-second strobe moves the live count into the snapshot, zeroes the live count and raises an interrupt flag.

Top module: `align_evt_counter`

## Requirements
- R1: With `count_en` high, a `mf_tick` cycle while `out_of_align` is high adds one to the upper field, bits 7:2 of the count word.
- R2: With `count_en` high, an `align_change` cycle adds one to the lower field, bits 1:0 of the count word.
- R3: With `count_en` low, no strobe changes the live count.
- R4: Neither field wraps. A field at all ones stays at all ones until the live count is cleared.
- R5: While `alarm_sim` is high, each `mf_tick` adds one to both fields, whatever `out_of_align` and `align_change` show.
- R6: In snapshot mode (`latch_mode` = 0) with no freeze active, a low-address read (`rd_hi` = 0) returns the live count as it stood before the most recent clock edge.
- R7: In snapshot mode, a `freeze_set` while `freeze_active` is low raises `freeze_active`, loads the snapshot with the pre-edge count and zeroes the live count. The snapshot then holds.
- R8: A read with `rd_en` and `rd_hi` high lowers `freeze_active`, and the snapshot tracks the live count again. A `freeze_set` in the same cycle as such a read, with `freeze_active` low, wins.
- R9: In periodic mode (`latch_mode` = 1), a `sec_tick` loads the snapshot with the pre-edge count, zeroes the live count and sets `sec_irq`. In this mode `freeze_set` has no effect.
- R10: `sec_irq` stays high until a low-address read (`rd_en` high, `rd_hi` low). A `sec_tick` in the same cycle as that read leaves it set.
- R11: An increment that falls in the same cycle as a clear of the live count is dropped, so the count restarts from zero.
- R12: Any change of `latch_mode` zeroes the live count and the snapshot and drops any freeze.
- R13: A read of the high-byte address (`rd_hi` = 1) returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | Enables both fields to count |
| latch_mode | input | 1 | 0 = snapshot mode, 1 = periodic one-second mode |
| out_of_align | input | 1 | Receiver is out of frame or multiframe alignment |
| mf_tick | input | 1 | One-cycle strobe, once per multiframe period |
| align_change | input | 1 | One-cycle strobe for a detected alignment change |
| alarm_sim | input | 1 | Alarm simulation active |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| freeze_set | input | 1 | Host write of 1 to the freeze request |
| rd_en | input | 1 | Host read strobe |
| rd_hi | input | 1 | Read address select: 0 = count byte, 1 = high byte |
| rd_data | output | 8 | Read data |
| freeze_active | output | 1 | Freeze request is pending |
| sec_irq | output | 1 | One-second interrupt flag |

## Verification
The bench drives the upper field up to 63 and the lower field up to 3, then keeps sending strobes. A design that wrapped would show small counts again. It sends increments in the same cycle as a freeze, a one-second strobe or a mode change. A design that let these through would start the new interval at one instead of zero. It also holds a freeze while counting continues and sends a freeze request together with a high-byte read. A design that fails here would show a snapshot that creeps forward or a freeze that never takes hold. Finally, it sends a one-second strobe in the same cycle as the read that clears the flag. A design that got the priority wrong would lose an interrupt.

// File: rtl/aec_pkg.sv
package aec_pkg;

    typedef struct packed {
        logic bump_upper;
        logic bump_lower;
    } aec_bump_t;

    typedef enum logic {
        RD_MODE_SNAP = 1'b0,
        RD_MODE_SEC  = 1'b1
    } aec_mode_e;

    function automatic aec_bump_t decode_bumps(
        input logic en,
        input logic mf,
        input logic ooa,
        input logic chg,
        input logic sim
    );
        aec_bump_t b;
        b.bump_upper = en && mf && (ooa || sim);
        b.bump_lower = en && (chg || (sim && mf));
        return b;
    endfunction

endpackage

// File: rtl/aec_sat_field.sv
module aec_sat_field #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (inc && (q != TOP)) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/aec_readout.sv
module aec_readout
    import aec_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_mode,
    input  logic              freeze_set,
    input  logic              sec_tick,
    input  logic              rd_en,
    input  logic              rd_hi,
    input  logic [WORD_W-1:0] live,
    output logic [WORD_W-1:0] snap_q,
    output logic              freeze_q,
    output logic              irq_q,
    output logic              mode_q,
    output logic              live_clr
);
    aec_mode_e mode_now;
    logic      mode_chg;
    logic      frz_rise;
    logic      sec_hit;
    logic      rd_hi_hit;
    logic      rd_lo_hit;

    always_comb begin
        mode_now  = aec_mode_e'(latch_mode);
        mode_chg  = (latch_mode != mode_q);
        frz_rise  = (mode_now == RD_MODE_SNAP) && freeze_set && !freeze_q;
        sec_hit   = (mode_now == RD_MODE_SEC) && sec_tick;
        rd_hi_hit = rd_en && rd_hi;
        rd_lo_hit = rd_en && !rd_hi;
        live_clr  = mode_chg || frz_rise || sec_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q   <= '0;
            freeze_q <= 1'b0;
            irq_q    <= 1'b0;
            mode_q   <= 1'b0;
        end else begin
            mode_q <= latch_mode;
            if (mode_chg) begin
                snap_q   <= '0;
                freeze_q <= 1'b0;
            end else begin
                if (mode_now == RD_MODE_SEC) begin
                    if (sec_hit) snap_q <= live;
                end else if (!freeze_q) begin
                    snap_q <= live;
                end
                if (frz_rise)       freeze_q <= 1'b1;
                else if (rd_hi_hit) freeze_q <= 1'b0;
            end
            if (sec_hit)        irq_q <= 1'b1;
            else if (rd_lo_hit) irq_q <= 1'b0;
        end
    end
endmodule

// File: rtl/align_evt_counter.sv
module align_evt_counter
    import aec_pkg::*;
#(
    parameter int UPPER_W = 6,
    parameter int LOWER_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       count_en,
    input  logic       latch_mode,
    input  logic       out_of_align,
    input  logic       mf_tick,
    input  logic       align_change,
    input  logic       alarm_sim,
    input  logic       sec_tick,
    input  logic       freeze_set,
    input  logic       rd_en,
    input  logic       rd_hi,
    output logic [UPPER_W+LOWER_W-1:0] rd_data,
    output logic       freeze_active,
    output logic       sec_irq
);
    localparam int WORD_W = UPPER_W + LOWER_W;

    aec_bump_t           bumps;
    logic [UPPER_W-1:0]  upper_q;
    logic [LOWER_W-1:0]  lower_q;
    logic [WORD_W-1:0]   live_word;
    logic [WORD_W-1:0]   snap_word;
    logic                live_clr;
    logic                mode_q;

    always_comb begin
        bumps     = decode_bumps(count_en, mf_tick, out_of_align, align_change, alarm_sim);
        live_word = {upper_q, lower_q};
        rd_data   = rd_hi ? '0 : snap_word;
    end

    aec_sat_field #(.W(UPPER_W)) u_upper (
        .clk (clk),
        .rst (rst),
        .clr (live_clr),
        .inc (bumps.bump_upper),
        .q   (upper_q)
    );

    aec_sat_field #(.W(LOWER_W)) u_lower (
        .clk (clk),
        .rst (rst),
        .clr (live_clr),
        .inc (bumps.bump_lower),
        .q   (lower_q)
    );

    aec_readout #(.WORD_W(WORD_W)) u_readout (
        .clk        (clk),
        .rst        (rst),
        .latch_mode (latch_mode),
        .freeze_set (freeze_set),
        .sec_tick   (sec_tick),
        .rd_en      (rd_en),
        .rd_hi      (rd_hi),
        .live       (live_word),
        .snap_q     (snap_word),
        .freeze_q   (freeze_active),
        .irq_q      (sec_irq),
        .mode_q     (mode_q),
        .live_clr   (live_clr)
    );
endmodule

// File: rtl/aec_checker.sv
module aec_checker #(
    parameter int UPPER_W = 6,
    parameter int LOWER_W = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       count_en,
    input logic                       latch_mode,
    input logic                       mode_q,
    input logic                       sec_tick,
    input logic                       rd_en,
    input logic                       rd_hi,
    input logic                       freeze_active,
    input logic                       sec_irq,
    input logic                       live_clr,
    input logic [UPPER_W+LOWER_W-1:0] live_word,
    input logic [UPPER_W+LOWER_W-1:0] snap_word,
    input logic [UPPER_W+LOWER_W-1:0] rd_data
);
    localparam int WORD_W = UPPER_W + LOWER_W;
    localparam logic [UPPER_W-1:0] UP_TOP = '1;
    localparam logic [LOWER_W-1:0] LO_TOP = '1;

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !live_clr) |=> $stable(live_word));

    assert_upper_sat_R4: assert property (@(posedge clk) disable iff (rst)
        (live_word[WORD_W-1:LOWER_W] == UP_TOP && !live_clr)
        |=> (live_word[WORD_W-1:LOWER_W] == UP_TOP));

    assert_lower_sat_R4: assert property (@(posedge clk) disable iff (rst)
        (live_word[LOWER_W-1:0] == LO_TOP && !live_clr)
        |=> (live_word[LOWER_W-1:0] == LO_TOP));

    assert_frozen_snap_R7: assert property (@(posedge clk) disable iff (rst)
        (freeze_active && (latch_mode == mode_q)) |=> $stable(snap_word));

    assert_sec_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (latch_mode && mode_q && sec_tick) |=> (sec_irq && live_word == '0));

    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (sec_irq && !(rd_en && !rd_hi)) |=> sec_irq);

    assert_clear_drops_R11: assert property (@(posedge clk) disable iff (rst)
        live_clr |=> (live_word == '0));

    assert_mode_flush_R12: assert property (@(posedge clk) disable iff (rst)
        (latch_mode != mode_q) |=> (snap_word == '0 && !freeze_active));

    assert_hi_read_zero_R13: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_hi) |-> (rd_data == '0));
endmodule

bind align_evt_counter aec_checker #(.UPPER_W(UPPER_W), .LOWER_W(LOWER_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .count_en      (count_en),
    .latch_mode    (latch_mode),
    .mode_q        (mode_q),
    .sec_tick      (sec_tick),
    .rd_en         (rd_en),
    .rd_hi         (rd_hi),
    .freeze_active (freeze_active),
    .sec_irq       (sec_irq),
    .live_clr      (live_clr),
    .live_word     (live_word),
    .snap_word     (snap_word),
    .rd_data       (rd_data)
);

// File: tb/align_evt_counter_tb.sv
module align_evt_counter_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic count_en = 1'b0, latch_mode = 1'b0, out_of_align = 1'b0, mf_tick = 1'b0;
    logic align_change = 1'b0, alarm_sim = 1'b0, sec_tick = 1'b0, freeze_set = 1'b0;
    logic rd_en = 1'b0, rd_hi = 1'b0;
    logic [7:0] rd_data;
    logic freeze_active, sec_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench reference state
    logic [5:0] m_up;
    logic [1:0] m_lo;
    logic [7:0] m_snap;
    logic m_frz, m_irq, m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    align_evt_counter u_dut (
        .clk(clk), .rst(rst), .count_en(count_en), .latch_mode(latch_mode),
        .out_of_align(out_of_align), .mf_tick(mf_tick), .align_change(align_change),
        .alarm_sim(alarm_sim), .sec_tick(sec_tick), .freeze_set(freeze_set),
        .rd_en(rd_en), .rd_hi(rd_hi), .rd_data(rd_data),
        .freeze_active(freeze_active), .sec_irq(sec_irq)
    );

    function automatic logic [5:0] sat6(input logic [5:0] v, input logic inc);
        return (inc && v != 6'h3f) ? v + 6'd1 : v;
    endfunction

    function automatic logic [1:0] sat2(input logic [1:0] v, input logic inc);
        return (inc && v != 2'h3) ? v + 2'd1 : v;
    endfunction

    task automatic model_reset();
        m_up = '0; m_lo = '0; m_snap = '0; m_frz = 0; m_irq = 0; m_mode = 0;
    endtask

    task automatic model_step();
        logic chg, rise, sec, clr, iu, il;
        logic [7:0] word;
        word = {m_up, m_lo};
        chg  = (latch_mode != m_mode);
        rise = !latch_mode && freeze_set && !m_frz;
        sec  = latch_mode && sec_tick;
        clr  = chg || rise || sec;
        iu   = count_en && mf_tick && (out_of_align || alarm_sim);
        il   = count_en && (align_change || (alarm_sim && mf_tick));
        if (chg) begin
            m_snap = '0; m_frz = 0;
        end else begin
            if (latch_mode) begin
                if (sec) m_snap = word;
            end else if (!m_frz) m_snap = word;
            if (rise) m_frz = 1;
            else if (rd_en && rd_hi) m_frz = 0;
        end
        if (sec) m_irq = 1;
        else if (rd_en && !rd_hi) m_irq = 0;
        if (clr) begin
            m_up = '0; m_lo = '0;
        end else begin
            m_up = sat6(m_up, iu); m_lo = sat2(m_lo, il);
        end
        m_mode = latch_mode;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " rd_data"}, rd_data, rd_hi ? 8'h00 : m_snap);
        check({tag, " freeze"}, {7'd0, freeze_active}, {7'd0, m_frz});
        check({tag, " irq"}, {7'd0, sec_irq}, {7'd0, m_irq});
    endtask

    // one clock: inputs already set; reference updates at the edge, sample 1 time unit later
    task automatic tick(input string tag);
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        #1;
        check_all(tag);
        mf_tick = 0; align_change = 0; sec_tick = 0; freeze_set = 0; rd_en = 0; rd_hi = 0;
    endtask

    task automatic mf_ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin mf_tick = 1; tick(tag); end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        model_reset();
        tick("reset");
        tick("reset");
        rst = 0;
        check("reset value", rd_data, 8'h00);

        // R1 upper field
        count_en = 1; out_of_align = 1;
        mf_ticks(3, "R1 upper count");
        tick("R1 settle");
        check("R1 upper field literal", rd_data, 8'h0c);
        // R2 lower field
        out_of_align = 0; align_change = 1; tick("R2 change");
        tick("R2 settle");
        check("R2 lower field literal", rd_data, 8'h0d);
        // R4 saturation of both fields
        for (int i = 0; i < 5; i++) begin align_change = 1; tick("R4 lower sat"); end
        out_of_align = 1;
        mf_ticks(70, "R4 upper sat");
        tick("R4 settle");
        check("R4 saturated word", rd_data, 8'hff);
        // R3 count_en low
        count_en = 0; freeze_set = 1; tick("R7 freeze");
        check("R7 freeze snapshot keeps pre-clear", rd_data, 8'hff);
        check("R7 freeze flag", {7'd0, freeze_active}, 8'h01);
        mf_ticks(4, "R3 disabled");
        align_change = 1; tick("R3 disabled");
        rd_en = 1; rd_hi = 1; tick("R13 hi read");
        check("R8 freeze cleared", {7'd0, freeze_active}, 8'h00);
        tick("R3 settle");
        check("R3 nothing counted", rd_data, 8'h00);
        // R5 alarm sim
        count_en = 1; out_of_align = 0; alarm_sim = 1;
        mf_ticks(2, "R5 alarm sim");
        alarm_sim = 0;
        tick("R5 settle");
        check("R5 both fields", rd_data, 8'h0a);
        // R11 increment in same cycle as freeze is dropped
        freeze_set = 1; mf_tick = 1; out_of_align = 1; tick("R11 freeze+inc");
        // R8 freeze_set beats same-cycle hi read
        rd_en = 1; rd_hi = 1; tick("R8 release");
        freeze_set = 1; rd_en = 1; rd_hi = 1; tick("R8 set wins");
        check("R8 set beats read", {7'd0, freeze_active}, 8'h01);
        rd_en = 1; rd_hi = 1; tick("R8 release");
        tick("R6 track");
        check("R11 restart from zero", rd_data, 8'h00);
        // R12 mode change, R9 periodic
        latch_mode = 1; mf_tick = 1; tick("R12 mode change");
        mf_ticks(2, "R9 count");
        freeze_set = 1; tick("R9 freeze ignored");
        check("R9 freeze ignored", {7'd0, freeze_active}, 8'h00);
        sec_tick = 1; tick("R9 sec");
        check("R9 latched", rd_data, 8'h08);
        check("R9 irq", {7'd0, sec_irq}, 8'h01);
        sec_tick = 1; rd_en = 1; tick("R10 sec with read");
        check("R10 irq kept", {7'd0, sec_irq}, 8'h01);
        rd_en = 1; tick("R10 read clears");
        check("R10 irq cleared", {7'd0, sec_irq}, 8'h00);
        latch_mode = 0; tick("R12 back");
        check("R12 snapshot flushed", rd_data, 8'h00);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            count_en     = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 299) == 0) latch_mode = ~latch_mode;
            out_of_align = $urandom_range(0, 1);
            mf_tick      = ($urandom_range(0, 3) == 0);
            align_change = ($urandom_range(0, 7) == 0);
            alarm_sim    = ($urandom_range(0, 19) == 0);
            sec_tick     = ($urandom_range(0, 49) == 0);
            freeze_set   = ($urandom_range(0, 29) == 0);
            rd_en        = ($urandom_range(0, 9) == 0);
            rd_hi        = $urandom_range(0, 1);
            tick("R6 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule